// File: doc/BRIEF.md
# ECC Memory Scrubber with Page Retirement Map

The block sweeps a RAM region that sits behind a single-error-correcting ECC stage. It reads each word back in turn. When the ECC stage reports a corrected word, the block writes the corrected value back. It then reads the word a second time to tell a transient upset from a stuck cell. Pages that hold a stuck cell or an uncorrectable word are retired in a bitmap. An allocator can query the bitmap combinationally. The bitmap is fetched from a small nonvolatile store after reset, and it is written back whenever it gains a bit.

A sweep runs when a programmable interval expires. It also runs when an on-demand pulse arrives, for instance around a high-radiation transit. The allocator can request a page. The block then walks a rotating pointer past retired pages and test-reads every word of the candidate page. A page whose test shows any ECC flag is retired, and the search moves on. If every page turns out retired, the allocator receives a failure pulse instead of a page.

The controller has the following states:
- LOAD: fetch the bitmap.
- IDLE
- STORE: save the bitmap.
- SWEEP_READ and SWEEP_WAIT: first read.
- WRITEBACK
- REREAD and REREAD_WAIT
- ALLOC_FIND, ALLOC_READ and ALLOC_WAIT.

Its transitions are:
- LOAD goes to IDLE when the load is acknowledged.
- IDLE goes to STORE when the bitmap is dirty. Otherwise it goes to ALLOC_FIND when an allocation is pending. Otherwise it goes to SWEEP_READ when a sweep is pending.
- SWEEP_READ skips a retired page, or issues a read once the port is free and moves to SWEEP_WAIT.
- SWEEP_WAIT moves on to the next word or page on a clean or uncorrectable response. It goes to WRITEBACK on a corrected response.
- WRITEBACK goes to REREAD, and REREAD goes to REREAD_WAIT.
- REREAD_WAIT returns to SWEEP_READ, or to IDLE after the last word.
- ALLOC_FIND loops over retired pages, or enters ALLOC_READ.
- ALLOC_READ goes to ALLOC_WAIT.
- ALLOC_WAIT continues with the next word, grants the page, or returns to ALLOC_FIND on a fault.

Top module: `ecc_scrubber`

## Requirements
- R1: After reset the block holds `nv_load_req` high and makes no memory access until `nv_load_ack` is seen. On that ack, `nv_load_map` becomes the retirement bitmap (bit p set = page p retired). A sweep requested during loading runs after the load.
- R2: A sweep starts at address `BASE_ADDR` and reads, in ascending order, every word of every page not retired. Page p covers word offsets p*2^PAGE_W to p*2^PAGE_W+2^PAGE_W-1.
- R3: With `interval_cfg` = N > 0, sweeps begin exactly N cycles apart. With N = 0, no periodic sweep occurs.
- R4: A one-cycle `scrub_now` pulse starts one extra sweep.
- R5: A corrected read is followed by one write of the returned data to the same address and one re-read. A clean re-read counts as a soft error in `soft_cnt`.
- R6: A re-read that still shows a flag counts in `hard_cnt` and retires the page. The remaining words of that page are not read in that sweep. Retired bits are never cleared except by a load.
- R7: An uncorrectable read counts in `uncorr_cnt` and retires the page without any write. It sets the sticky `irq` with `irq_addr` holding the first failing address. `irq_clr` clears `irq`.
- R8: The sweep never reads or writes a word in a retired page.
- R9: While `mem_busy` is high, no access is taken, and the pending request is held with a stable address and direction.
- R10: The three error counters start at zero and saturate at 2^CNT_W-1.
- R11: An allocation request grants the next page in rotation that is not retired and whose words all read without a flag. A page failing that test is retired, and the search continues with the following page.
- R12: Whenever the bitmap has gained a bit, the block raises `nv_store_req` with the full bitmap on `nv_store_map` until `nv_store_ack`. Without a change, no store occurs.
- R13: `q_bad` shows the bitmap bit of page `q_page` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| interval_cfg | input | INT_W | sweep period in cycles, 0 disables |
| scrub_now | input | 1 | on-demand sweep pulse |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | word address |
| mem_wdata | output | DATA_W | write data |
| mem_busy | input | 1 | port taken by foreground traffic |
| mem_rvalid | input | 1 | read response valid |
| mem_rdata | input | DATA_W | corrected read data |
| mem_corr | input | 1 | response had a corrected error |
| mem_uncorr | input | 1 | response had an uncorrectable error |
| q_page | input | PG_W | page to query |
| q_bad | output | 1 | queried page is retired |
| alloc_req | input | 1 | allocation request pulse |
| alloc_valid | output | 1 | granted page valid pulse |
| alloc_page | output | PG_W | granted page |
| alloc_fail | output | 1 | no healthy page pulse |
| nv_load_req | output | 1 | bitmap fetch request |
| nv_load_ack | input | 1 | fetch complete |
| nv_load_map | input | PAGES | fetched bitmap |
| nv_store_req | output | 1 | bitmap save request |
| nv_store_ack | input | 1 | save complete |
| nv_store_map | output | PAGES | bitmap to save |
| irq | output | 1 | sticky uncorrectable-error flag |
| irq_addr | output | ADDR_W | first uncorrectable address |
| irq_clr | input | 1 | clears irq |
| scrub_busy | output | 1 | sweep in progress |
| soft_cnt | output | CNT_W | soft error count |
| hard_cnt | output | CNT_W | hard error count |
| uncorr_cnt | output | CNT_W | uncorrectable error count |

## Verification
Most internal faults in this block surface at the memory port within a cycle or two. A wrong sweep offset or page-skip decision shows up as a read of a retired page, or as a missing word in the per-address read tally, during the same sweep. A misclassification shows up as a wrong write count on the faulty word, or as a counter off by one, as soon as the re-read response returns. A bitmap that loses or gains a bit shows on `q_bad` the same cycle, and in the next `nv_store_map` image. A broken interval counter shows as a sweep-to-sweep spacing different from `interval_cfg`.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
    typedef enum logic [3:0] {
        ST_LOAD,
        ST_IDLE,
        ST_STORE,
        ST_RD,
        ST_RWAIT,
        ST_WB,
        ST_RRD,
        ST_RRWAIT,
        ST_AFIND,
        ST_ARD,
        ST_AWAIT
    } scrub_state_e;
endpackage

// File: rtl/scrub_interval_timer.sv
module scrub_interval_timer #(
    parameter int INT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INT_W-1:0] interval_i,
    output logic             tick_o
);
    logic [INT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap   = (interval_i != '0) && (cnt_q >= interval_i - INT_W'(1));
    assign tick_o = wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (interval_i == '0)   cnt_q <= '0;
        else if (wrap)               cnt_q <= '0;
        else                         cnt_q <= cnt_q + INT_W'(1);
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && interval_i > INT_W'(1) && $stable(interval_i)) |=> !tick_o); // R3
endmodule

// File: rtl/scrub_sat_counter.sv
module scrub_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);
    logic [W-1:0] cnt_q;
    assign count_o = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (inc_i && cnt_q != '1)   cnt_q <= cnt_q + W'(1);
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1) |=> (cnt_q == '1)); // R10
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/scrub_page_map.sv
module scrub_page_map #(
    parameter int PAGES = 16,
    localparam int PG_W = $clog2(PAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [PAGES-1:0] load_map_i,
    input  logic             set_i,
    input  logic [PG_W-1:0]  set_page_i,
    input  logic             stored_i,
    input  logic [PG_W-1:0]  q_page_i,
    output logic             q_bad_o,
    output logic [PAGES-1:0] map_o,
    output logic             dirty_o
);
    logic [PAGES-1:0] map_q;
    logic             dirty_q;

    assign map_o   = map_q;
    assign dirty_o = dirty_q;
    assign q_bad_o = map_q[q_page_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q   <= '0;
            dirty_q <= 1'b0;
        end else begin
            if (load_i)      map_q <= load_map_i;
            else if (set_i)  map_q[set_page_i] <= 1'b1;
            if (set_i && !map_q[set_page_i]) dirty_q <= 1'b1;
            else if (stored_i)               dirty_q <= 1'b0;
        end
    end

    AST_MAP_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (($past(map_q) & ~map_q) == '0)); // R6
    AST_SET_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !load_i && !map_q[set_page_i]) |=> dirty_q); // R12
endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
    import scrub_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int NUM_WORDS = 64,
    parameter int PAGE_W = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    localparam int OFF_W = $clog2(NUM_WORDS),
    localparam int PG_W = OFF_W - PAGE_W,
    localparam int PAGES = NUM_WORDS >> PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              scrub_now_i,
    input  logic              alloc_req_i,
    input  logic              irq_clr_i,
    input  logic              nv_load_ack_i,
    input  logic              nv_store_ack_i,
    input  logic              dirty_i,
    input  logic [PAGES-1:0]  map_i,
    input  logic              mem_busy_i,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_corr_i,
    input  logic              mem_uncorr_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              nv_load_req_o,
    output logic              nv_store_req_o,
    output logic              map_load_o,
    output logic              store_done_o,
    output logic              set_o,
    output logic [PG_W-1:0]   set_page_o,
    output logic              ev_soft_o,
    output logic              ev_hard_o,
    output logic              ev_uncorr_o,
    output logic              irq_o,
    output logic [ADDR_W-1:0] irq_addr_o,
    output logic              busy_o,
    output logic              alloc_valid_o,
    output logic              alloc_fail_o,
    output logic [PG_W-1:0]   alloc_page_o
);
    localparam logic [PG_W:0] LAST_TRY = (PG_W+1)'(PAGES - 1);

    scrub_state_e      state_q, state_d;
    logic [OFF_W-1:0]  off_q;
    logic [DATA_W-1:0] wb_q;
    logic              pend_q, apend_q;
    logic [PG_W-1:0]   aptr_q;
    logic [PAGE_W-1:0] aw_q;
    logic [PG_W:0]     tries_q;
    logic              irq_q;
    logic [ADDR_W-1:0] irq_addr_q;

    logic [PG_W-1:0]   cur_page;
    logic [OFF_W-1:0]  next_page_off;
    logic              last_word, last_page, flag, alloc_acc;
    logic              go_store, go_alloc, go_sweep;

    assign cur_page      = off_q[OFF_W-1:PAGE_W];
    assign next_page_off = {cur_page + PG_W'(1), {PAGE_W{1'b0}}};
    assign last_word     = (off_q == '1);
    assign last_page     = (cur_page == '1);
    assign flag          = mem_corr_i | mem_uncorr_i;
    assign go_store      = dirty_i;
    assign go_alloc      = !dirty_i && apend_q;
    assign go_sweep      = !dirty_i && !apend_q && pend_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:   if (nv_load_ack_i) state_d = ST_IDLE;
            ST_IDLE: begin
                if (go_store)      state_d = ST_STORE;
                else if (go_alloc) state_d = ST_AFIND;
                else if (go_sweep) state_d = ST_RD;
            end
            ST_STORE:  if (nv_store_ack_i) state_d = ST_IDLE;
            ST_RD: begin
                if (map_i[cur_page])  state_d = last_page ? ST_IDLE : ST_RD;
                else if (!mem_busy_i) state_d = ST_RWAIT;
            end
            ST_RWAIT: if (mem_rvalid_i) begin
                if (mem_uncorr_i)    state_d = last_page ? ST_IDLE : ST_RD;
                else if (mem_corr_i) state_d = ST_WB;
                else                 state_d = last_word ? ST_IDLE : ST_RD;
            end
            ST_WB:     if (!mem_busy_i) state_d = ST_RRD;
            ST_RRD:    if (!mem_busy_i) state_d = ST_RRWAIT;
            ST_RRWAIT: if (mem_rvalid_i) begin
                if (flag) state_d = last_page ? ST_IDLE : ST_RD;
                else      state_d = last_word ? ST_IDLE : ST_RD;
            end
            ST_AFIND: begin
                if (map_i[aptr_q]) state_d = (tries_q == LAST_TRY) ? ST_IDLE : ST_AFIND;
                else               state_d = ST_ARD;
            end
            ST_ARD:    if (!mem_busy_i) state_d = ST_AWAIT;
            ST_AWAIT: if (mem_rvalid_i) begin
                if (flag)            state_d = (tries_q == LAST_TRY) ? ST_IDLE : ST_AFIND;
                else if (aw_q == '1) state_d = ST_IDLE;
                else                 state_d = ST_ARD;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        alloc_acc      = (state_q == ST_ARD) || (state_q == ST_AWAIT);
        mem_addr_o     = BASE_ADDR + ADDR_W'(alloc_acc ? {aptr_q, aw_q} : off_q);
        mem_req_o      = ((state_q == ST_RD) && !map_i[cur_page]) || (state_q == ST_WB)
                         || (state_q == ST_RRD) || (state_q == ST_ARD);
        mem_we_o       = (state_q == ST_WB);
        mem_wdata_o    = wb_q;
        nv_load_req_o  = (state_q == ST_LOAD);
        map_load_o     = (state_q == ST_LOAD) && nv_load_ack_i;
        nv_store_req_o = (state_q == ST_STORE);
        store_done_o   = (state_q == ST_STORE) && nv_store_ack_i;
        ev_soft_o      = (state_q == ST_RRWAIT) && mem_rvalid_i && !flag;
        ev_hard_o      = (state_q == ST_RRWAIT) && mem_rvalid_i && flag;
        ev_uncorr_o    = (state_q == ST_RWAIT) && mem_rvalid_i && mem_uncorr_i;
        set_o          = ev_hard_o || ev_uncorr_o
                         || ((state_q == ST_AWAIT) && mem_rvalid_i && flag);
        set_page_o     = (state_q == ST_AWAIT) ? aptr_q : cur_page;
        busy_o         = (state_q == ST_RD) || (state_q == ST_RWAIT) || (state_q == ST_WB)
                         || (state_q == ST_RRD) || (state_q == ST_RRWAIT);
        alloc_valid_o  = (state_q == ST_AWAIT) && mem_rvalid_i && !flag && (aw_q == '1);
        alloc_page_o   = aptr_q;
        alloc_fail_o   = (tries_q == LAST_TRY) &&
                         (((state_q == ST_AFIND) && map_i[aptr_q]) ||
                          ((state_q == ST_AWAIT) && mem_rvalid_i && flag));
        irq_o          = irq_q;
        irq_addr_o     = irq_addr_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q      <= '0;
            wb_q       <= '0;
            pend_q     <= 1'b0;
            apend_q    <= 1'b0;
            aptr_q     <= '0;
            aw_q       <= '0;
            tries_q    <= '0;
            irq_q      <= 1'b0;
            irq_addr_q <= '0;
        end else begin
            if (state_q == ST_IDLE && go_sweep) pend_q <= 1'b0;
            if (tick_i || scrub_now_i)          pend_q <= 1'b1;
            if (state_q == ST_IDLE && go_alloc) apend_q <= 1'b0;
            if (alloc_req_i)                    apend_q <= 1'b1;
            if (irq_clr_i) irq_q <= 1'b0;
            if (ev_uncorr_o && !irq_q) begin
                irq_q      <= 1'b1;
                irq_addr_q <= mem_addr_o;
            end
            case (state_q)
                ST_IDLE: begin
                    if (go_sweep) off_q   <= '0;
                    if (go_alloc) tries_q <= '0;
                end
                ST_RD: if (map_i[cur_page]) off_q <= next_page_off;
                ST_RWAIT: if (mem_rvalid_i) begin
                    if (mem_uncorr_i)    off_q <= next_page_off;
                    else if (mem_corr_i) wb_q  <= mem_rdata_i;
                    else                 off_q <= off_q + OFF_W'(1);
                end
                ST_RRWAIT: if (mem_rvalid_i) begin
                    if (flag) off_q <= next_page_off;
                    else      off_q <= off_q + OFF_W'(1);
                end
                ST_AFIND: begin
                    if (map_i[aptr_q]) begin
                        aptr_q  <= aptr_q + PG_W'(1);
                        tries_q <= tries_q + (PG_W+1)'(1);
                    end else begin
                        aw_q <= '0;
                    end
                end
                ST_AWAIT: if (mem_rvalid_i) begin
                    if (flag) begin
                        aptr_q  <= aptr_q + PG_W'(1);
                        tries_q <= tries_q + (PG_W+1)'(1);
                    end else if (aw_q == '1) begin
                        aptr_q <= aptr_q + PG_W'(1);
                    end else begin
                        aw_q <= aw_q + PAGE_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    AST_NO_ACCESS_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
        nv_load_req_o |-> !mem_req_o && !alloc_valid_o); // R1
    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_busy_i) |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R9
    AST_NO_RETIRED_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !alloc_acc) |-> !map_i[cur_page]); // R8
    AST_WRITE_AFTER_CORR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> !mem_uncorr_i); // R7
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clr_i) |=> irq_q && $stable(irq_addr_q)); // R7
endmodule

// File: rtl/ecc_scrubber.sv
module ecc_scrubber #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int NUM_WORDS = 64,
    parameter int PAGE_W = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40,
    parameter int INT_W = 40,
    parameter int CNT_W = 8,
    localparam int PAGES = NUM_WORDS >> PAGE_W,
    localparam int PG_W = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INT_W-1:0]  interval_cfg,
    input  logic              scrub_now,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_busy,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_corr,
    input  logic              mem_uncorr,
    input  logic [PG_W-1:0]   q_page,
    output logic              q_bad,
    input  logic              alloc_req,
    output logic              alloc_valid,
    output logic [PG_W-1:0]   alloc_page,
    output logic              alloc_fail,
    output logic              nv_load_req,
    input  logic              nv_load_ack,
    input  logic [PAGES-1:0]  nv_load_map,
    output logic              nv_store_req,
    input  logic              nv_store_ack,
    output logic [PAGES-1:0]  nv_store_map,
    output logic              irq,
    output logic [ADDR_W-1:0] irq_addr,
    input  logic              irq_clr,
    output logic              scrub_busy,
    output logic [CNT_W-1:0]  soft_cnt,
    output logic [CNT_W-1:0]  hard_cnt,
    output logic [CNT_W-1:0]  uncorr_cnt
);
    localparam int NUM_CNT = 3;

    logic             tick, dirty, map_load, store_done, set_en;
    logic [PG_W-1:0]  set_page;
    logic [PAGES-1:0] map;
    logic             ev_soft, ev_hard, ev_uncorr;
    logic [NUM_CNT-1:0] inc_vec;
    logic [CNT_W-1:0] cnt_arr [NUM_CNT];

    assign nv_store_map = map;

    scrub_interval_timer #(.INT_W(INT_W)) i_timer (
        .clk, .rst_n, .interval_i(interval_cfg), .tick_o(tick)
    );

    scrub_page_map #(.PAGES(PAGES)) i_map (
        .clk, .rst_n,
        .load_i(map_load), .load_map_i(nv_load_map),
        .set_i(set_en), .set_page_i(set_page),
        .stored_i(store_done),
        .q_page_i(q_page), .q_bad_o(q_bad),
        .map_o(map), .dirty_o(dirty)
    );

    scrub_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS),
        .PAGE_W(PAGE_W), .BASE_ADDR(BASE_ADDR)
    ) i_ctrl (
        .clk, .rst_n,
        .tick_i(tick), .scrub_now_i(scrub_now), .alloc_req_i(alloc_req),
        .irq_clr_i(irq_clr), .nv_load_ack_i(nv_load_ack), .nv_store_ack_i(nv_store_ack),
        .dirty_i(dirty), .map_i(map),
        .mem_busy_i(mem_busy), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
        .mem_corr_i(mem_corr), .mem_uncorr_i(mem_uncorr),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata),
        .nv_load_req_o(nv_load_req), .nv_store_req_o(nv_store_req),
        .map_load_o(map_load), .store_done_o(store_done),
        .set_o(set_en), .set_page_o(set_page),
        .ev_soft_o(ev_soft), .ev_hard_o(ev_hard), .ev_uncorr_o(ev_uncorr),
        .irq_o(irq), .irq_addr_o(irq_addr), .busy_o(scrub_busy),
        .alloc_valid_o(alloc_valid), .alloc_fail_o(alloc_fail), .alloc_page_o(alloc_page)
    );

    assign inc_vec = {ev_uncorr, ev_hard, ev_soft};

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        scrub_sat_counter #(.W(CNT_W)) i_cnt (
            .clk, .rst_n, .inc_i(inc_vec[g]), .count_o(cnt_arr[g])
        );
    end

    assign soft_cnt   = cnt_arr[0];
    assign hard_cnt   = cnt_arr[1];
    assign uncorr_cnt = cnt_arr[2];

    AST_EVENT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(inc_vec) <= 1); // R5
    AST_STORE_IMAGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_store_req && !nv_store_ack) |=> $stable(nv_store_map)); // R12
endmodule

// File: tb/test_ecc_scrubber.sv
`timescale 1ns/1ps
module test_ecc_scrubber;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int NW = 64;
    localparam int PAGE_W = 2;
    localparam int PAGES = 16;
    localparam int PG_W = 4;
    localparam int INT_W = 40;
    localparam int CNT_W = 3;
    localparam logic [ADDR_W-1:0] BASE = 8'h40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [INT_W-1:0]  interval_cfg = '0;
    logic              scrub_now = 1'b0;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_busy = 1'b0;
    logic              mem_rvalid = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              mem_corr = 1'b0, mem_uncorr = 1'b0;
    logic [PG_W-1:0]   q_page = '0;
    logic              q_bad;
    logic              alloc_req = 1'b0, alloc_valid, alloc_fail;
    logic [PG_W-1:0]   alloc_page;
    logic              nv_load_req, nv_load_ack = 1'b0;
    logic [PAGES-1:0]  nv_load_map = '0;
    logic              nv_store_req, nv_store_ack = 1'b0;
    logic [PAGES-1:0]  nv_store_map;
    logic              irq, irq_clr = 1'b0, scrub_busy;
    logic [ADDR_W-1:0] irq_addr;
    logic [CNT_W-1:0]  soft_cnt, hard_cnt, uncorr_cnt;

    ecc_scrubber #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NW), .PAGE_W(PAGE_W),
        .BASE_ADDR(BASE), .INT_W(INT_W), .CNT_W(CNT_W)
    ) i_ecc_scrubber (.*);

    int nvec = 0, nerr = 0;
    int cyc = 0;

    // behavioural ECC memory: kind 0 clean, 1 soft flip, 2 stuck cell, 3 double error
    logic [DATA_W-1:0] mdat [NW];
    int kind [NW];
    int rd_cnt [NW];
    int wr_cnt [NW];
    int first_addr = -1;
    logic busy_en = 1'b0, hold_busy = 1'b0;
    logic [PAGES-1:0] saved_map = '0;
    int store_cnt = 0;

    always @(posedge clk) begin
        int idx;
        mem_rvalid <= 1'b0;
        mem_corr   <= 1'b0;
        mem_uncorr <= 1'b0;
        if (mem_req && !mem_busy) begin
            idx = int'(mem_addr) - int'(BASE);
            if (mem_we) begin
                mdat[idx] = mem_wdata;
                wr_cnt[idx]++;
                if (kind[idx] == 1) kind[idx] = 0;
            end else begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= (kind[idx] == 3) ? ~mdat[idx] : mdat[idx];
                mem_corr   <= (kind[idx] == 1) || (kind[idx] == 2);
                mem_uncorr <= (kind[idx] == 3);
                rd_cnt[idx]++;
                if (first_addr < 0) first_addr = int'(mem_addr);
            end
        end
        nv_store_ack <= nv_store_req && !nv_store_ack;
        if (nv_store_req && !nv_store_ack) begin
            saved_map = nv_store_map;
            store_cnt++;
        end
    end

    always @(negedge clk) mem_busy <= hold_busy || (busy_en && ($urandom % 100) < 30);

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int total_rd(input int lo, input int hi);
        int s = 0;
        for (int i = lo; i <= hi; i++) s += rd_cnt[i];
        return s;
    endfunction

    function automatic int total_wr(input int lo, input int hi);
        int s = 0;
        for (int i = lo; i <= hi; i++) s += wr_cnt[i];
        return s;
    endfunction

    function automatic int sat(input int n);
        return (n > (1 << CNT_W) - 1) ? (1 << CNT_W) - 1 : n;
    endfunction

    task automatic clear_tally();
        for (int i = 0; i < NW; i++) begin
            rd_cnt[i] = 0;
            wr_cnt[i] = 0;
        end
        first_addr = -1;
    endtask

    task automatic wait_pass_end();
        while (!scrub_busy) @(negedge clk);
        while (scrub_busy) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    task automatic pulse_now();
        @(negedge clk) scrub_now = 1'b1;
        @(negedge clk) scrub_now = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            nvec++;
            nerr++;
            $display("FAIL watchdog: actual %0d expected run end", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] orig1;
        int miss, t1, t2, picked, acc0;
        void'($urandom(32'd11));
        for (int i = 0; i < NW; i++) begin
            mdat[i] = DATA_W'($urandom);
            kind[i] = 0;
        end
        clear_tally();
        repeat (3) @(negedge clk);
        // reset state
        chk("R1", "load request in reset", nv_load_req, 1);
        chk("R10", "soft count at reset", soft_cnt, 0);
        chk("R7", "irq at reset", irq, 0);
        rst_n = 1'b1;

        // R1: sweep request while loading must wait
        pulse_now();
        repeat (20) @(negedge clk);
        chk("R1", "reads before load ack", total_rd(0, NW-1), 0);
        chk("R1", "load request held", nv_load_req, 1);

        // faults for the first sweep
        kind[1] = 1; kind[5] = 1; kind[9] = 2; kind[22] = 3; kind[13] = 2;
        orig1 = mdat[1];
        busy_en = 1'b1;
        nv_load_map = 16'h0008;
        nv_load_ack = 1'b1;
        @(negedge clk) nv_load_ack = 1'b0;
        q_page = 4'd3;
        #0 chk("R13", "loaded page 3 retired", q_bad, 1);
        q_page = 4'd2;
        #1 chk("R13", "page 2 healthy", q_bad, 0);
        wait_pass_end();

        chk("R2", "first sweep address", first_addr, BASE);
        miss = 0;
        for (int i = 0; i < NW; i++)
            if (!((i / 4) inside {2, 3, 5}) && rd_cnt[i] == 0) miss++;
        chk("R2", "unread healthy words", miss, 0);
        chk("R5", "soft count", soft_cnt, sat(2));
        chk("R5", "reads of soft word", rd_cnt[1], 2);
        chk("R5", "writes to soft word", wr_cnt[1], 1);
        chk("R5", "soft word data", mdat[1], orig1);
        chk("R6", "hard count", hard_cnt, 1);
        chk("R6", "writes to stuck word", wr_cnt[9], 1);
        chk("R6", "reads after stuck word", rd_cnt[10] + rd_cnt[11], 0);
        chk("R7", "uncorrectable count", uncorr_cnt, 1);
        chk("R7", "irq set", irq, 1);
        chk("R7", "irq address", irq_addr, BASE + 8'd22);
        chk("R7", "writes to double-error word", wr_cnt[22], 0);
        chk("R8", "accesses to page 3", total_rd(12, 15) + total_wr(12, 15), 0);
        chk("R12", "stored map", saved_map, 16'h002C);
        chk("R12", "store count", store_cnt, 1);
        q_page = 4'd5;
        #1 chk("R13", "page 5 retired", q_bad, 1);

        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        chk("R7", "irq cleared", irq, 0);

        // R4 on-demand sweep with R9 stall
        clear_tally();
        pulse_now();
        while (!scrub_busy) @(negedge clk);
        repeat (3) @(negedge clk);
        hold_busy = 1'b1;
        @(negedge clk);
        acc0 = total_rd(0, NW-1) + total_wr(0, NW-1);
        repeat (50) @(negedge clk);
        chk("R9", "accesses while busy", total_rd(0, NW-1) + total_wr(0, NW-1), acc0);
        chk("R9", "request held", mem_req, 1);
        hold_busy = 1'b0;
        wait_pass_end();
        chk("R4", "on-demand sweep started at base", first_addr, BASE);
        chk("R5", "soft count after clean sweep", soft_cnt, sat(2));
        chk("R8", "accesses to pages 2 and 5", total_rd(8, 11) + total_rd(20, 23)
            + total_wr(8, 11) + total_wr(20, 23), 0);
        chk("R12", "no store without change", store_cnt, 1);

        // R10 saturation: nine random soft faults in healthy pages
        picked = 0;
        while (picked < 9) begin
            int w;
            w = int'($urandom % NW);
            if (!((w / 4) inside {2, 3, 5}) && kind[w] == 0) begin
                kind[w] = 1;
                picked++;
            end
        end
        pulse_now();
        wait_pass_end();
        chk("R10", "soft count saturated", soft_cnt, sat(2 + 9));
        chk("R10", "hard count unchanged", hard_cnt, 1);

        // R3 interval
        @(negedge clk) interval_cfg = 40'd400;
        while (!scrub_busy) @(negedge clk);
        t1 = cyc;
        while (scrub_busy) @(negedge clk);
        while (!scrub_busy) @(negedge clk);
        t2 = cyc;
        interval_cfg = '0;
        chk("R3", "sweep spacing", t2 - t1, 400);
        while (scrub_busy) @(negedge clk);
        clear_tally();
        repeat (1000) @(negedge clk);
        chk("R3", "no sweep when disabled", total_rd(0, NW-1), 0);

        // R11 allocation
        kind[2] = 2;
        @(negedge clk) alloc_req = 1'b1;
        @(negedge clk) alloc_req = 1'b0;
        while (!(alloc_valid || alloc_fail)) @(negedge clk);
        chk("R11", "first grant valid", alloc_valid, 1);
        chk("R11", "first grant page", alloc_page, 1);
        repeat (10) @(negedge clk);
        q_page = 4'd0;
        #1 chk("R11", "failed page retired", q_bad, 1);
        chk("R12", "stored map after test fail", saved_map, 16'h002D);
        @(negedge clk) alloc_req = 1'b1;
        @(negedge clk) alloc_req = 1'b0;
        while (!(alloc_valid || alloc_fail)) @(negedge clk);
        chk("R11", "second grant page", alloc_page, 4);

        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule